// File: doc/BRIEF.md
# Multi-Lane Radix Carry Propagator

The block adds two vectors of N digits. All digits in a vector share one radix, and software picks that radix at run time. Each lane first adds its pair of digits with no carry. From that local sum the lane flags a generate, meaning it overflows on its own, or a propagate, meaning it sits exactly at radix-1. The generate flags of all lanes are packed into one integer and the propagate flags into another. A single integer expression, ((P|G)+G)^P, then gives the carry into every lane at once. Each lane wraps its local sum plus its incoming carry back into the radix.

A carry-in bit enters below lane 0. The carry leaving the top lane is reported as the carry-out. A flag tells whether any lane passed a carry upward. A one-cycle `start` loads the result registers, and `done` pulses in the following cycle alongside the new results.

Top module: `radix_carry_adder`

## Requirements
- R1: Lane i occupies bits [i*W +: W] of each digit bus. The output digit of lane i is (a_i + b_i + k_i) mod radix, where k_i is the carry into that lane.
- R2: A lane whose local sum a_i + b_i is radix or more sends a carry into lane i+1, with or without an incoming carry.
- R3: A lane whose local sum equals radix-1 passes its incoming carry on to the next lane, and a carry can cross a chain of such lanes in one operation.
- R4: `carry_in` is the carry into lane 0.
- R5: `carry_out` is the carry leaving lane N-1, equal to G | (P & carry into that lane) for the top lane.
- R6: `any_carry` is 1 when at least one lane (the top lane included) sends a carry upward, and 0 otherwise, even when lanes sit at radix-1 with no carry reaching them.
- R7: The radix is a run-time input from 2 to 2^W. Binary lanes and full-width lanes (radix 2^W) give correct digits and carries.
- R8: The results load on a cycle with `start` high, and `done` is high for exactly the next cycle. Without `start`, the results hold their values whatever the inputs do.
- R9: After reset, `done`, `sum_digits`, `carry_out` and `any_carry` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load results from the current inputs |
| a_digits | input | N*W | First digit vector, lane i at [i*W +: W] |
| b_digits | input | N*W | Second digit vector |
| radix | input | W+1 | Radix, 2 to 2^W |
| carry_in | input | 1 | Carry into lane 0 |
| done | output | 1 | One-cycle pulse after start |
| sum_digits | output | N*W | Result digits |
| carry_out | output | 1 | Carry out of lane N-1 |
| any_carry | output | 1 | Some lane sent a carry upward |

## Verification
The bench aims at the packed carry resolution. It drives a carry-in that must ripple through seven radix-1 lanes in one step. A wrong mask or a one-bit shift in the packed addition would stop that chain early or shift it into the wrong lane. It also sets up lanes that sit at radix-1 with no carry arriving. A flag derived from the propagate bits rather than from real carries would wrongly report movement there. Radix 2 and radix 2^W stress the comparison widths: a truncated radix-1 or a narrow local sum would misclassify generate and propagate lanes. A hold test changes every input while `start` is low and confirms that the registered results stay put.

// File: rtl/radix_carry_adder.sv
module radix_carry_adder #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*W-1:0] a_digits,
  input  logic [N*W-1:0] b_digits,
  input  logic [W:0]     radix,
  input  logic           carry_in,
  output logic           done,
  output logic [N*W-1:0] sum_digits,
  output logic           carry_out,
  output logic           any_carry
);
  localparam int XW = N + 2;

  logic [N-1:0]   gen, prop;
  logic [XW-1:0]  p_ext, g_ext;
  logic [N:0]     lane_c;
  logic [N*W-1:0] next_digits;

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [W:0]   local_sum;
    logic [W+1:0] total;
    assign local_sum = {1'b0, a_digits[i*W +: W]} + {1'b0, b_digits[i*W +: W]};
    assign gen[i]  = local_sum >= radix;
    assign prop[i] = local_sum == radix - 1'b1;
    assign total   = {1'b0, local_sum} + {{(W+1){1'b0}}, lane_c[i]};
    assign next_digits[i*W +: W] = W'((total >= {1'b0, radix}) ? total - {1'b0, radix} : total);
  end

  assign p_ext  = {1'b0, prop, 1'b0};
  assign g_ext  = {1'b0, gen, carry_in};
  assign lane_c = (N+1)'((((p_ext | g_ext) + g_ext) ^ p_ext) >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      sum_digits <= '0;
      carry_out  <= 1'b0;
      any_carry  <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        sum_digits <= next_digits;
        carry_out  <= lane_c[N];
        any_carry  <= |lane_c[N:1];
      end
    end
  end
endmodule

// File: rtl/radix_carry_adder_checker.sv
module radix_carry_adder_checker #(
  parameter int N = 8,
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [N*W-1:0] a_digits,
  input logic [N*W-1:0] b_digits,
  input logic [W:0]     radix,
  input logic           carry_in,
  input logic           done,
  input logic [N*W-1:0] sum_digits,
  input logic           carry_out,
  input logic           any_carry
);
  logic ripple_cout;
  logic digits_ok;
  logic [W:0] radix_q;

  always_comb begin
    logic c;
    logic [W+1:0] t;
    c = carry_in;
    for (int i = 0; i < N; i++) begin
      t = {2'b00, a_digits[i*W +: W]} + {2'b00, b_digits[i*W +: W]} + {{(W+1){1'b0}}, c};
      c = t >= {1'b0, radix};
    end
    ripple_cout = c;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) radix_q <= '0;
    else if (start) radix_q <= radix;

  always_comb begin
    digits_ok = 1'b1;
    for (int i = 0; i < N; i++)
      if ({1'b0, sum_digits[i*W +: W]} >= radix_q) digits_ok = 1'b0;
  end

  assert_done_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_no_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(sum_digits) && $stable(carry_out) && $stable(any_carry)));
  assert_cout_ripple_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> carry_out == $past(ripple_cout));
  assert_cout_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> any_carry);
  assert_digit_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> digits_ok);
endmodule

bind radix_carry_adder radix_carry_adder_checker #(.N(N), .W(W)) chk (
  .clk(clk), .rst_n(rst_n), .start(start), .a_digits(a_digits),
  .b_digits(b_digits), .radix(radix), .carry_in(carry_in), .done(done),
  .sum_digits(sum_digits), .carry_out(carry_out), .any_carry(any_carry)
);

// File: tb/radix_carry_adder_test.sv
`timescale 1ns/1ps
module radix_carry_adder_test;
  localparam int N = 8;
  localparam int W = 8;

  typedef struct {
    logic [N*W-1:0] digits;
    logic           cout;
    logic           moved;
    string          tag;
  } exp_t;

  logic clk = 0, rst_n = 0, start = 0, carry_in = 0;
  logic [N*W-1:0] a_digits = '0, b_digits = '0;
  logic [W:0] radix = 10;
  logic done, carry_out, any_carry;
  logic [N*W-1:0] sum_digits;

  int checks = 0, errors = 0, seen = 0, sent = 0;
  bit finished = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  radix_carry_adder #(.N(N), .W(W)) uut (.*);

  task automatic check(string tag, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(logic [N*W-1:0] a, logic [N*W-1:0] b,
                                 int r, logic cin, string tag);
    exp_t e;
    int c = cin;
    e.moved = 0;
    for (int i = 0; i < N; i++) begin
      int t = int'(a[i*W +: W]) + int'(b[i*W +: W]) + c;
      if (t >= r) begin t -= r; c = 1; e.moved = 1; end else c = 0;
      e.digits[i*W +: W] = W'(t);
    end
    e.cout = c[0];
    e.tag = tag;
    return e;
  endfunction

  function automatic logic [N*W-1:0] rep(int v);
    logic [N*W-1:0] x;
    for (int i = 0; i < N; i++) x[i*W +: W] = W'(v);
    return x;
  endfunction

  task automatic send(logic [N*W-1:0] a, logic [N*W-1:0] b, int r, logic cin, string tag);
    sb.push_back(model(a, b, r, cin, tag));
    sent++;
    @(negedge clk);
    a_digits = a; b_digits = b; radix = (W+1)'(r); carry_in = cin; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n && done) begin
    exp_t e;
    if (sb.size() == 0) begin
      checks++; errors++;
      $display("FAIL R8 actual=done expected=no pending result");
    end else begin
      e = sb.pop_front();
      check({e.tag, " digits"}, sum_digits, e.digits);
      check({e.tag, " carry_out"}, {{(N*W-1){1'b0}}, carry_out}, {{(N*W-1){1'b0}}, e.cout});
      check({e.tag, " any_carry"}, {{(N*W-1){1'b0}}, any_carry}, {{(N*W-1){1'b0}}, e.moved});
    end
    seen++;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [N*W-1:0] a, b, held;
    repeat (3) @(negedge clk);
    check("R9 digits", sum_digits, '0);
    check("R9 flags", {{(N*W-3){1'b0}}, done, carry_out, any_carry}, '0);
    rst_n = 1;
    @(negedge clk);

    send(rep(2), rep(3), 10, 0, "R1 plain decimal");
    a = rep(1); b = rep(1); a[0 +: W] = 5; b[0 +: W] = 7;
    send(a, b, 10, 0, "R2 lane0 generate");
    a = rep(4); b = rep(5); a[7*W +: W] = 1; b[7*W +: W] = 1;
    send(a, b, 10, 1, "R3 R4 chain of seven");
    send(rep(4), rep(5), 10, 1, "R5 full ripple carry_out");
    send(rep(4), rep(5), 10, 0, "R6 propagate without carry");
    a = '0; b = '0; a[3*W +: W] = 9; b[3*W +: W] = 9; a[4*W +: W] = 4; b[4*W +: W] = 5;
    send(a, b, 10, 0, "R2 R3 generate into propagate");
    a = {8'd1, 8'd0, 8'd1, 8'd1, 8'd0, 8'd1, 8'd0, 8'd1};
    b = {8'd1, 8'd0, 8'd0, 8'd1, 8'd1, 8'd0, 8'd0, 8'd1};
    send(a, b, 2, 1, "R7 binary lanes");
    a = rep(255); b = '0; b[0 +: W] = 1;
    send(a, b, 256, 0, "R7 full radix ripple");
    a = rep(128); b = rep(127);
    send(a, b, 256, 1, "R7 full radix carry_in chain");
    a = {8'd15, 8'd3, 8'd8, 8'd15, 8'd0, 8'd9, 8'd12, 8'd7};
    b = {8'd0, 8'd12, 8'd8, 8'd1, 8'd15, 8'd6, 8'd3, 8'd9};
    send(a, b, 16, 0, "R1 mixed hex");

    held = sum_digits;
    a_digits = rep(99); b_digits = rep(99); radix = 3; carry_in = 1;
    repeat (3) @(negedge clk);
    check("R8 hold digits", sum_digits, held);
    check("R8 no done without start", {{(N*W-1){1'b0}}, done}, '0);

    repeat (3) @(negedge clk);
    check("R8 results consumed", (N*W)'(sb.size()), '0);
    check("R8 done count", (N*W)'(seen), (N*W)'(sent));
    finish_run();
  end
endmodule